// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the fault-confinement status of a CAN node. The protocol engine reports each detected bus error as a one-cycle strobe carrying a 3-bit error type and a flag saying whether the node was transmitting or receiving. It also reports each frame sent or received without error. From these events the block maintains a transmit error counter and a receive error counter. From the counters it decodes a warning flag, an error-passive flag and a bus-off flag.

The block also holds the type of the most recent bus error in a small code field. The field returns to zero after any good frame. Software may write the field through a one-cycle write strobe. Hardware never produces type 7, so software can preload 7 and poll the field to see when hardware next touches it. Once the node goes bus-off, both counters freeze. They stay frozen until the protocol engine, having finished its recovery sequence, pulses the recovery input.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters read 0, all three flags read 0 and the code field reads 0.
- R2: An error strobe with `err_on_tx`=1 adds 8 to the transmit counter. An error strobe with `err_on_tx`=0 adds 1 to the receive counter, and the receive counter saturates at 255.
- R3: `tx_ok` subtracts 1 from the transmit counter and `rx_ok` subtracts 1 from the receive counter. Neither counter goes below 0. When a counter gets an error increment and a decrement in the same cycle, only the increment applies.
- R4: `warn` is 1 exactly when either counter is 96 or more.
- R5: `passive` is 1 exactly when either counter is 128 or more.
- R6: `bus_off` is 1 exactly when the transmit counter exceeds 255. While `bus_off` is 1, both counters ignore error and success strobes.
- R7: `recover` clears both counters in the next cycle in any state. It takes precedence over every other counter event in that cycle.
- R8: An error strobe loads `err_code` into the code field. Valid hardware types are 1 to 6.
- R9: `tx_ok` or `rx_ok` without an error strobe in the same cycle clears the code field to 0.
- R10: `sw_wr` loads `sw_code` into the code field only in a cycle with no error strobe and no success strobe. A preloaded 7 stays until hardware changes the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_stb | input | 1 | Bus error detected this cycle |
| err_on_tx | input | 1 | 1: error counts against the transmitter; 0: against the receiver |
| err_code | input | 3 | Type of the detected error (1 to 6) |
| tx_ok | input | 1 | Frame transmitted successfully |
| rx_ok | input | 1 | Frame received successfully |
| recover | input | 1 | Clear both counters (end of bus-off recovery) |
| sw_wr | input | 1 | Software write to the code field |
| sw_code | input | 3 | Value written by software |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| warn | output | 1 | Either counter at warning level (96 or more) |
| passive | output | 1 | Either counter above 127 |
| bus_off | output | 1 | Transmit counter above 255 |
| last_code | output | 3 | Last error type field |

## Verification
Every input event takes effect at the next rising edge, so the counters and the code field show it one cycle after the strobe. The flags decode the registered counters, so they change in that same cycle with no extra delay. The bench drives its inputs just after the falling edge and updates a behavioural model at the rising edge. It compares all six outputs at the following falling edge, which gives exactly the one-cycle latency. Directed checks read the outputs one idle cycle after their stimulus, at the point where that latency has elapsed.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    // Counter widths and code width
    localparam int TEC_BITS  = 9;
    localparam int REC_BITS  = 8;
    localparam int CODE_BITS = 3;

    // Fault-confinement thresholds and steps
    localparam int WARN_AT      = 96;
    localparam int PASSIVE_OVER = 127;
    localparam int BUSOFF_OVER  = 255;
    localparam int TX_STEP      = 8;
    localparam int RX_STEP      = 1;

    // Error-type encoding of the code field
    typedef enum logic [CODE_BITS-1:0] {
        EC_NONE  = 3'd0,
        EC_STUFF = 3'd1,
        EC_FORM  = 3'd2,
        EC_ACK   = 3'd3,
        EC_BIT_R = 3'd4,
        EC_BIT_D = 3'd5,
        EC_CRC   = 3'd6,
        EC_SWMARK = 3'd7
    } err_code_e;

    // Decoded status flags
    typedef struct packed {
        logic warn;
        logic passive;
        logic bus_off;
    } fc_flags_t;

    // Source selected for the code field
    typedef enum logic [1:0] {
        CS_KEEP,
        CS_HW,
        CS_CLEAR,
        CS_SW
    } code_src_e;

    function automatic code_src_e pick_code_src(input logic hw, input logic ok, input logic sw);
        if (hw)      return CS_HW;
        else if (ok) return CS_CLEAR;
        else if (sw) return CS_SW;
        return CS_KEEP;
    endfunction

endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
    parameter int W        = 8,
    parameter int STEP     = 1,
    parameter bit SATURATE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         hold,
    input  logic         bump,
    input  logic         drop,
    output logic [W-1:0] cnt
);
    localparam logic [W:0] MAXV  = {1'b0, {W{1'b1}}};
    localparam logic [W:0] STEPV = (W+1)'(STEP);

    logic [W:0]   sum;
    logic [W-1:0] bumped;

    assign sum = {1'b0, cnt} + STEPV;

    generate
        if (SATURATE) begin : g_sat
            assign bumped = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
        end else begin : g_wrap
            assign bumped = sum[W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!hold) begin
            if (bump)
                cnt <= bumped;
            else if (drop && (cnt != '0))
                cnt <= cnt - 1'b1;
        end
    end

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && drop && !bump && !clr) |=> (cnt == '0)); // R3

    AST_CNT_BUMP_WINS: assert property (@(posedge clk) disable iff (rst)
        (bump && drop && !hold && !clr && cnt != '0) |=> (cnt != $past(cnt) - 1'b1)); // R3

endmodule

// File: rtl/fc_state_decode.sv
module fc_state_decode
    import can_fc_pkg::*;
#(
    parameter int TW = TEC_BITS,
    parameter int RW = REC_BITS,
    parameter int WARN_LIM = WARN_AT,
    parameter int PASS_LIM = PASSIVE_OVER,
    parameter int BOFF_LIM = BUSOFF_OVER
) (
    input  logic [TW-1:0] tec,
    input  logic [RW-1:0] rec,
    output fc_flags_t     flags
);
    localparam logic [TW-1:0] T_WARN = TW'(WARN_LIM);
    localparam logic [TW-1:0] T_PASS = TW'(PASS_LIM);
    localparam logic [TW-1:0] T_BOFF = TW'(BOFF_LIM);
    localparam logic [RW-1:0] R_WARN = RW'(WARN_LIM);
    localparam logic [RW-1:0] R_PASS = RW'(PASS_LIM);

    always_comb begin
        flags.warn    = (tec >= T_WARN) || (rec >= R_WARN);
        flags.passive = (tec >  T_PASS) || (rec >  R_PASS);
        flags.bus_off = (tec >  T_BOFF);
    end

endmodule

// File: rtl/fc_code_reg.sv
module fc_code_reg
    import can_fc_pkg::*;
#(
    parameter int CW = CODE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_stb,
    input  logic [CW-1:0] hw_code,
    input  logic          ok_stb,
    input  logic          sw_wr,
    input  logic [CW-1:0] sw_code,
    output logic [CW-1:0] code
);
    code_src_e src;

    always_comb src = pick_code_src(hw_stb, ok_stb, sw_wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else begin
            unique case (src)
                CS_HW:    code <= hw_code;
                CS_CLEAR: code <= '0;
                CS_SW:    code <= sw_code;
                default:  code <= code;
            endcase
        end
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hw_stb && !ok_stb && !sw_wr) |=> $stable(code)); // R10

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
    import can_fc_pkg::*;
#(
    parameter int TW = TEC_BITS,
    parameter int RW = REC_BITS,
    parameter int CW = CODE_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          err_stb,
    input  logic          err_on_tx,
    input  logic [CW-1:0] err_code,
    input  logic          tx_ok,
    input  logic          rx_ok,
    input  logic          recover,
    input  logic          sw_wr,
    input  logic [CW-1:0] sw_code,
    output logic [TW-1:0] tec,
    output logic [RW-1:0] rec,
    output logic          warn,
    output logic          passive,
    output logic          bus_off,
    output logic [CW-1:0] last_code
);
    fc_flags_t flags;
    logic      frozen;
    logic      tx_err, rx_err;

    assign frozen = flags.bus_off;
    assign tx_err = err_stb &&  err_on_tx;
    assign rx_err = err_stb && !err_on_tx;

    fc_err_counter #(.W(TW), .STEP(TX_STEP), .SATURATE(1'b0)) u_tec (
        .clk(clk), .rst(rst), .clr(recover), .hold(frozen),
        .bump(tx_err), .drop(tx_ok), .cnt(tec)
    );

    fc_err_counter #(.W(RW), .STEP(RX_STEP), .SATURATE(1'b1)) u_rec (
        .clk(clk), .rst(rst), .clr(recover), .hold(frozen),
        .bump(rx_err), .drop(rx_ok), .cnt(rec)
    );

    fc_state_decode #(.TW(TW), .RW(RW)) u_dec (
        .tec(tec), .rec(rec), .flags(flags)
    );

    fc_code_reg #(.CW(CW)) u_code (
        .clk(clk), .rst(rst), .hw_stb(err_stb), .hw_code(err_code),
        .ok_stb(tx_ok || rx_ok), .sw_wr(sw_wr), .sw_code(sw_code),
        .code(last_code)
    );

    assign warn    = flags.warn;
    assign passive = flags.passive;
    assign bus_off = flags.bus_off;

    AST_TX_STEP: assert property (@(posedge clk) disable iff (rst)
        (tx_err && !recover && !bus_off) |=> (tec == $past(tec) + TW'(TX_STEP))); // R2
    AST_PASSIVE_WARN: assert property (@(posedge clk) disable iff (rst)
        passive |-> warn); // R5
    AST_BUSOFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_off && !recover) |=> ($stable(tec) && $stable(rec))); // R6
    AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        recover |=> (tec == '0 && rec == '0)); // R7
    AST_CODE_HW: assert property (@(posedge clk) disable iff (rst)
        err_stb |=> (last_code == $past(err_code))); // R8
    AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!err_stb && (tx_ok || rx_ok)) |=> (last_code == '0)); // R9
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !err_stb && !tx_ok && !rx_ok) |=> (last_code == $past(sw_code))); // R10

endmodule

// File: tb/can_fault_tracker_test.sv
module can_fault_tracker_test;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       err_stb, err_on_tx, tx_ok, rx_ok, recover, sw_wr;
    logic [2:0] err_code, sw_code;
    logic [8:0] tec;
    logic [7:0] rec;
    logic       warn, passive, bus_off;
    logic [2:0] last_code;

    int n_chk = 0;
    int n_bad = 0;
    int m_tec, m_rec, m_code;
    bit done = 0;
    bit live = 0;

    always #(CLK_NS/2) clk = ~clk;

    can_fault_tracker uut (
        .clk(clk), .rst(rst), .err_stb(err_stb), .err_on_tx(err_on_tx),
        .err_code(err_code), .tx_ok(tx_ok), .rx_ok(rx_ok), .recover(recover),
        .sw_wr(sw_wr), .sw_code(sw_code), .tec(tec), .rec(rec), .warn(warn),
        .passive(passive), .bus_off(bus_off), .last_code(last_code)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_tec = 0; m_rec = 0; m_code = 0;
        end else begin
            if (recover) begin
                m_tec = 0; m_rec = 0;
            end else if (m_tec <= 255) begin
                if (err_stb && err_on_tx)  m_tec = m_tec + 8;
                else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
                if (err_stb && !err_on_tx) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
                else if (rx_ok && m_rec > 0) m_rec = m_rec - 1;
            end
            if (err_stb)             m_code = int'(err_code);
            else if (tx_ok || rx_ok) m_code = 0;
            else if (sw_wr)          m_code = int'(sw_code);
        end
    end

    // Compare every cycle at the falling edge
    always @(negedge clk) begin
        if (live) begin
            chk("R2 tec",      int'(tec),       m_tec);
            chk("R2 rec",      int'(rec),       m_rec);
            chk("R4 warn",     int'(warn),      int'(m_tec >= 96 || m_rec >= 96));
            chk("R5 passive",  int'(passive),   int'(m_tec > 127 || m_rec > 127));
            chk("R6 bus_off",  int'(bus_off),   int'(m_tec > 255));
            chk("R8 code",     int'(last_code), m_code);
        end
    end

    task automatic drive(bit e, bit etx, int ec, bit tok, bit rok, bit rcv, bit sw, int sc);
        @(negedge clk);
        err_stb = e; err_on_tx = etx; err_code = 3'(ec);
        tx_ok = tok; rx_ok = rok; recover = rcv; sw_wr = sw; sw_code = 3'(sc);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1;
        err_stb = 0; err_on_tx = 0; err_code = 0; tx_ok = 0; rx_ok = 0;
        recover = 0; sw_wr = 0; sw_code = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        live = 1;
        // R1 reset state
        chk("R1 tec", int'(tec), 0);
        chk("R1 rec", int'(rec), 0);
        chk("R1 flags", int'({warn, passive, bus_off}), 0);
        chk("R1 code", int'(last_code), 0);

        // R4 warning threshold
        repeat (11) drive(1, 1, 3, 0, 0, 0, 0, 0);
        idle();
        chk("R4 warn below 96", int'(warn), 0);
        drive(1, 1, 3, 0, 0, 0, 0, 0);
        idle();
        chk("R4 warn at 96", int'(warn), 1);
        chk("R5 passive at 96", int'(passive), 0);
        repeat (4) drive(1, 1, 3, 0, 0, 0, 0, 0);
        idle();
        chk("R5 passive at 128", int'(passive), 1);
        chk("R8 code type 3", int'(last_code), 3);
        drive(0, 0, 0, 1, 0, 0, 0, 0);
        idle();
        chk("R5 passive at 127", int'(passive), 0);
        chk("R9 code cleared by tx_ok", int'(last_code), 0);

        // R6 bus-off entry and hold
        repeat (16) drive(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk("R6 tec 255", int'(tec), 255);
        chk("R6 no bus_off at 255", int'(bus_off), 0);
        drive(1, 1, 1, 0, 0, 0, 0, 0);
        idle();
        chk("R6 bus_off at 263", int'(bus_off), 1);
        chk("R6 tec 263", int'(tec), 263);
        drive(0, 0, 0, 1, 1, 0, 0, 0);
        drive(1, 0, 2, 0, 0, 0, 0, 0);
        drive(1, 1, 2, 0, 0, 0, 0, 0);
        idle();
        chk("R6 tec held", int'(tec), 263);
        chk("R6 rec held", int'(rec), 0);

        // R7 recovery beats a same-cycle error
        drive(1, 1, 4, 0, 0, 1, 0, 0);
        idle();
        chk("R7 tec cleared", int'(tec), 0);
        chk("R7 bus_off dropped", int'(bus_off), 0);

        // R3 floor and increment priority
        drive(0, 0, 0, 1, 1, 0, 0, 0);
        idle();
        chk("R3 tec floor", int'(tec), 0);
        chk("R3 rec floor", int'(rec), 0);
        drive(1, 1, 5, 1, 0, 0, 0, 0);
        idle();
        chk("R3 increment wins", int'(tec), 8);
        drive(0, 0, 0, 0, 0, 1, 0, 0);

        // R2 receive saturation
        repeat (260) drive(1, 0, 2, 0, 0, 0, 0, 0);
        idle();
        chk("R2 rec saturates", int'(rec), 255);
        chk("R5 passive from rec", int'(passive), 1);
        drive(0, 0, 0, 0, 1, 0, 0, 0);
        idle();
        chk("R3 rec decrement", int'(rec), 254);

        // R10 software preload
        drive(0, 0, 0, 0, 0, 1, 1, 7);
        idle(); idle();
        chk("R10 preload 7 kept", int'(last_code), 7);
        drive(1, 0, 6, 0, 0, 0, 0, 0);
        idle();
        chk("R8 hw overwrites preload", int'(last_code), 6);
        drive(1, 1, 5, 0, 0, 0, 1, 7);
        idle();
        chk("R10 hw beats sw write", int'(last_code), 5);
        drive(0, 0, 0, 0, 1, 0, 1, 7);
        idle();
        chk("R9 success beats sw write", int'(last_code), 0);

        // Mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            drive(r < 40, $urandom_range(0, 2) != 0, int'($urandom_range(1, 6)),
                  $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0,
                  $urandom_range(0, 199) == 0, $urandom_range(0, 9) == 0,
                  int'($urandom_range(0, 7)));
        end
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule